// File: doc/BRIEF.md
# Serial Command DAC Register Interface

This block is the digital front end of a serially loaded digital-to-analog converter. A host drives a serial clock, a data line and an active-low chip-select that doubles as the load strobe. While the select is low, bits enter a 20-bit shift register MSB first. When the select returns high, the top four bits of that register are decoded as a command. The command may stage the 16-bit data word in an input buffer, move the staged word into the DAC buffer, load both buffers at once, or select one of six output ranges while loading both buffers. One command copies the DAC buffer and range into the shift register so that a host can read them back.

The serial pins are brought into the block's clock domain through a configurable synchronizer. Edges are then detected on the system clock. The DAC buffer word and the 3-bit range code are the block's outputs toward the analog section. The serial output carries the oldest bit of the shift register, so that several parts can be chained on one select line. An asynchronous active-low clear returns all storage to zero code.

Top module: `dac_serial_if`

## Requirements
- R1: While `cs_n` is low, each rising edge of `sck` shifts `sdi` into bit 0 of the 20-bit shift register, and earlier bits move one place up. While `cs_n` is high, `sck` edges do not change the shift register.
- R2: `sdo` always shows bit 19 of the shift register, which is the bit shifted in earliest, so the first bit of a frame leaves first on the next frame.
- R3: On the strobe, the command is bits 19..16 and the data word is bits 15..0, which are the last 20 bits shifted in. Bits shifted in before those are discarded.
- R4: `dac_word` and `range_code` change only as the result of a rising edge of `cs_n`, never during shifting.
- R5: Command 4'b0000 loads the data word into the input buffer and leaves `dac_word` unchanged.
- R6: Command 4'b0001 copies the input buffer into the DAC buffer (`dac_word`).
- R7: Command 4'b0010 loads the data word into both buffers.
- R8: Commands 4'b0100 to 4'b1001 load the data word into both buffers and set `range_code` to 0 to 5 in the same order: 0 is 0..5 V, 1 is 0..10 V, 2 is ±5 V, 3 is ±10 V, 4 is ±2.5 V, 5 is -2.5..7.5 V.
- R9: The reserved commands 4'b0011 and 4'b1010 to 4'b1101 change neither buffer nor the range.
- R10: Command 4'b1111 is a no-operation.
- R11: Command 4'b1110 loads the shift register with {1'b0, range_code, dac_word}, so the next frame shifts that word out on `sdo`, MSB first.
- R12: While `clr_n` is low, both buffers and the shift register hold zero and `range_code` is 0 (0..5 V), independent of the clock.
- R13: If an `sck` rising edge arrives in the same cycle as the `cs_n` rising edge, that edge does not shift, and the command acts on the register contents from before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| clr_n | input | 1 | Asynchronous active-low clear of all storage |
| sck | input | 1 | Serial clock; shifts on rising edge |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low select; rising edge executes the command |
| sdo | output | 1 | Serial data out, bit 19 of the shift register |
| dac_word | output | DATA_W | DAC buffer contents |
| range_code | output | 3 | Selected output range code |

## Verification
A final serial clock edge and the select's rising edge can be detected in the same system-clock cycle. When that happens, the shift must not happen and the command must decode the register contents from before that edge. The bench provokes this by raising `sck` and `cs_n` on the same clock with `sdi` at 1, after a complete frame. It judges the result by `dac_word` and `range_code`: a wrongly taken shift turns the frame into a range command carrying a different word. A property on the top module also requires the shift register to stay stable after such a cycle whenever the command is not a readback.

// File: rtl/dsi_pkg.sv
package dsi_pkg;

   localparam int CMD_W   = 4;
   localparam int RANGE_W = 3;
   localparam logic [RANGE_W-1:0] RANGE_AT_CLEAR = 3'd0;

   typedef enum logic [CMD_W-1:0] {
      OP_STAGE     = 4'h0,
      OP_PROMOTE   = 4'h1,
      OP_LOAD_BOTH = 4'h2,
      OP_RNG_FIRST = 4'h4,
      OP_RNG_LAST  = 4'h9,
      OP_READBACK  = 4'hE,
      OP_IDLE      = 4'hF
   } dsi_op_e;

   typedef struct packed {
      logic               stage_wr;    // input buffer <= data word
      logic               out_wr;      // DAC buffer <= data word
      logic               promote;     // DAC buffer <= input buffer
      logic               range_wr;    // range <= range_val
      logic [RANGE_W-1:0] range_val;
      logic               readback;    // shift register <= status
   } dsi_act_t;

endpackage

// File: rtl/dsi_sync.sv
module dsi_sync #(
   parameter int               WIDTH     = 1,
   parameter int               STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("dsi_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] pipe;
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RESET_VAL;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dsi_decode.sv
module dsi_decode
   import dsi_pkg::*;
(
   input  logic             strobe,
   input  logic [CMD_W-1:0] cmd,
   output dsi_act_t         act
);

   logic [CMD_W-1:0] rng_ofs;
   assign rng_ofs = cmd - CMD_W'(OP_RNG_FIRST);

   always_comb begin
      act = '0;
      if (strobe) begin
         if (cmd == OP_STAGE) begin
            act.stage_wr = 1'b1;
         end else if (cmd == OP_PROMOTE) begin
            act.promote = 1'b1;
         end else if (cmd == OP_LOAD_BOTH) begin
            act.stage_wr = 1'b1;
            act.out_wr   = 1'b1;
         end else if (cmd >= OP_RNG_FIRST && cmd <= OP_RNG_LAST) begin
            act.stage_wr  = 1'b1;
            act.out_wr    = 1'b1;
            act.range_wr  = 1'b1;
            act.range_val = rng_ofs[RANGE_W-1:0];
         end else if (cmd == OP_READBACK) begin
            act.readback = 1'b1;
         end
      end
   end

endmodule

// File: rtl/dsi_shifter.sv
module dsi_shifter #(
   parameter int FRAME_W = 20
) (
   input  logic               clk,
   input  logic               clr_n,
   input  logic               shift_en,
   input  logic               bit_in,
   input  logic               load_en,
   input  logic [FRAME_W-1:0] load_word,
   output logic [FRAME_W-1:0] sreg,
   output logic               sdo
);

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)        sreg <= '0;
      else if (load_en)  sreg <= load_word;
      else if (shift_en) sreg <= {sreg[FRAME_W-2:0], bit_in};
   end

   assign sdo = sreg[FRAME_W-1];

   assert_sdo_follows_R2: assert property (@(posedge clk) disable iff (!clr_n)
      (shift_en && !load_en) |=> sdo == $past(sreg[FRAME_W-2]));

   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!clr_n)
      (!shift_en && !load_en) |=> $stable(sreg));

endmodule

// File: rtl/dsi_regs.sv
module dsi_regs
   import dsi_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic               clk,
   input  logic               clr_n,
   input  dsi_act_t           act,
   input  logic [DATA_W-1:0]  data_in,
   output logic [DATA_W-1:0]  out_word,
   output logic [RANGE_W-1:0] range_q
);

   logic [DATA_W-1:0] stage_q;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         stage_q  <= '0;
         out_word <= '0;
         range_q  <= RANGE_AT_CLEAR;
      end else begin
         if (act.stage_wr) stage_q <= data_in;
         if (act.out_wr)       out_word <= data_in;
         else if (act.promote) out_word <= stage_q;
         if (act.range_wr) range_q <= act.range_val;
      end
   end

   assert_promote_copies_R6: assert property (@(posedge clk) disable iff (!clr_n)
      (act.promote && !act.out_wr) |=> out_word == $past(stage_q));

   assert_stage_only_R5: assert property (@(posedge clk) disable iff (!clr_n)
      (act.stage_wr && !act.out_wr && !act.promote) |=> $stable(out_word));

   assert_both_loaded_R7: assert property (@(posedge clk) disable iff (!clr_n)
      (act.stage_wr && act.out_wr) |=> (out_word == $past(data_in)) && (stage_q == $past(data_in)));

endmodule

// File: rtl/dac_serial_if.sv
module dac_serial_if
   import dsi_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               clr_n,
   input  logic               sck,
   input  logic               sdi,
   input  logic               cs_n,
   output logic               sdo,
   output logic [DATA_W-1:0]  dac_word,
   output logic [RANGE_W-1:0] range_code
);

   localparam int FRAME_W = CMD_W + DATA_W;
   localparam int PAD_W   = FRAME_W - RANGE_W - DATA_W;

   generate
      if (DATA_W < 2 || DATA_W > 32) begin : g_bad_width
         $error("dac_serial_if: DATA_W must be 2..32");
      end
      if (PAD_W < 0) begin : g_bad_pad
         $error("dac_serial_if: status word does not fit the frame");
      end
   endgenerate

   // synchronized pins: {cs_n, sck, sdi}, select idles high
   logic [2:0] pins_s;
   logic       csn_s, sck_s, sdi_s;
   logic       csn_q, sck_q;
   logic       sck_rise, strobe, shift_en;

   dsi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
      .clk   (clk),
      .clr_n (clr_n),
      .d     ({cs_n, sck, sdi}),
      .q     (pins_s)
   );
   assign {csn_s, sck_s, sdi_s} = pins_s;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         csn_q <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         csn_q <= csn_s;
         sck_q <= sck_s;
      end
   end

   assign sck_rise = sck_s & ~sck_q;
   assign strobe   = csn_s & ~csn_q;
   assign shift_en = sck_rise & ~csn_s;   // a rise coinciding with the strobe is dropped

   logic [FRAME_W-1:0] sreg;
   logic [FRAME_W-1:0] status_word;
   logic [CMD_W-1:0]   cmd;
   dsi_act_t           act;

   assign cmd         = sreg[FRAME_W-1 -: CMD_W];
   assign status_word = {{PAD_W{1'b0}}, range_code, dac_word};

   dsi_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk       (clk),
      .clr_n     (clr_n),
      .shift_en  (shift_en),
      .bit_in    (sdi_s),
      .load_en   (act.readback),
      .load_word (status_word),
      .sreg      (sreg),
      .sdo       (sdo)
   );

   dsi_decode u_dec (
      .strobe (strobe),
      .cmd    (cmd),
      .act    (act)
   );

   dsi_regs #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .clr_n    (clr_n),
      .act      (act),
      .data_in  (sreg[DATA_W-1:0]),
      .out_word (dac_word),
      .range_q  (range_code)
   );

   assert_no_strobe_no_change_R4: assert property (@(posedge clk) disable iff (!clr_n)
      !strobe |=> $stable(dac_word) && $stable(range_code));

   assert_reserved_inert_R9: assert property (@(posedge clk) disable iff (!clr_n)
      (strobe && (cmd == 4'h3 || (cmd >= 4'hA && cmd <= 4'hD))) |=> $stable(dac_word) && $stable(range_code));

   assert_idle_inert_R10: assert property (@(posedge clk) disable iff (!clr_n)
      (strobe && cmd == 4'hF) |=> $stable(dac_word) && $stable(range_code) && $stable(sreg));

   assert_range_select_R8: assert property (@(posedge clk) disable iff (!clr_n)
      (strobe && cmd >= 4'h4 && cmd <= 4'h9) |=> range_code == 3'($past(cmd) - 4'd4));

   assert_readback_load_R11: assert property (@(posedge clk) disable iff (!clr_n)
      (strobe && cmd == 4'hE) |=> sreg == {{PAD_W{1'b0}}, $past(range_code), $past(dac_word)});

   assert_edge_at_strobe_R13: assert property (@(posedge clk) disable iff (!clr_n)
      (sck_rise && strobe && cmd != 4'hE) |=> $stable(sreg));

endmodule

// File: tb/dac_serial_if_tb.sv
module dac_serial_if_tb_top;

   logic        clk = 1'b0;
   logic        clr_n, sck, sdi, cs_n;
   logic        sdo;
   logic [15:0] dac_word;
   logic [2:0]  range_code;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   dac_serial_if #(.DATA_W(16), .SYNC_STAGES(2)) dut_i (
      .clk        (clk),
      .clr_n      (clr_n),
      .sck        (sck),
      .sdi        (sdi),
      .cs_n       (cs_n),
      .sdo        (sdo),
      .dac_word   (dac_word),
      .range_code (range_code)
   );

   // vector: {req id, command, data word, expected dac_word, expected range_code}
   localparam int NV = 19;
   localparam logic [42:0] VECS [NV] = '{
      {4'd5,  4'h0, 16'hA5A5, 16'h0000, 3'd0},  // R5 stage only
      {4'd6,  4'h1, 16'h0000, 16'hA5A5, 3'd0},  // R6 promote
      {4'd7,  4'h2, 16'h1234, 16'h1234, 3'd0},  // R7 both
      {4'd8,  4'h4, 16'h1111, 16'h1111, 3'd0},  // R8 range 0
      {4'd8,  4'h5, 16'h2222, 16'h2222, 3'd1},
      {4'd8,  4'h6, 16'h3333, 16'h3333, 3'd2},
      {4'd8,  4'h7, 16'h4444, 16'h4444, 3'd3},
      {4'd8,  4'h8, 16'h5555, 16'h5555, 3'd4},
      {4'd8,  4'h9, 16'h6666, 16'h6666, 3'd5},
      {4'd9,  4'h3, 16'h7777, 16'h6666, 3'd5},  // R9 reserved
      {4'd9,  4'hA, 16'h7777, 16'h6666, 3'd5},
      {4'd9,  4'hB, 16'h7777, 16'h6666, 3'd5},
      {4'd9,  4'hC, 16'h7777, 16'h6666, 3'd5},
      {4'd9,  4'hD, 16'h7777, 16'h6666, 3'd5},
      {4'd10, 4'hF, 16'h8888, 16'h6666, 3'd5},  // R10 no-op
      {4'd6,  4'h1, 16'h0000, 16'h6666, 3'd5},  // input buffer kept range load
      {4'd5,  4'h0, 16'h9999, 16'h6666, 3'd5},
      {4'd9,  4'hC, 16'hABCD, 16'h6666, 3'd5},  // reserved leaves input buffer
      {4'd9,  4'h1, 16'h0000, 16'h9999, 3'd5}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic half();
      repeat (4) @(negedge clk);
   endtask

   task automatic shift_bits(input logic [31:0] w, input int n);
      cs_n = 1'b0;
      half();
      for (int i = n - 1; i >= 0; i--) begin
         sdi = w[i];
         half();
         sck = 1'b1;
         half();
         sck = 1'b0;
      end
      half();
   endtask

   task automatic raise_cs();
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic frame(input logic [3:0] c, input logic [15:0] d);
      shift_bits({12'h0, c, d}, 20);
      raise_cs();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [19:0] cap;
      clr_n = 1'b0; sck = 1'b0; sdi = 1'b0; cs_n = 1'b1;
      repeat (5) @(negedge clk);
      // R12 state under clear
      check("R12 dac in clear", 32'(dac_word), 32'h0);
      check("R12 range in clear", 32'(range_code), 32'h0);
      check("R12 sdo in clear", 32'(sdo), 32'h0);
      clr_n = 1'b1;
      repeat (5) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         frame(VECS[v][38:35], VECS[v][34:19]);
         check($sformatf("R%0d vec%0d dac", VECS[v][42:39], v), 32'(dac_word), 32'(VECS[v][18:3]));
         check($sformatf("R%0d vec%0d range", VECS[v][42:39], v), 32'(range_code), 32'(VECS[v][2:0]));
      end

      // R1: sck ignored while cs_n high
      frame(4'h0, 16'h1357);
      sdi = 1'b1;
      for (int k = 0; k < 5; k++) begin
         half(); sck = 1'b1; half(); sck = 1'b0;
      end
      cs_n = 1'b0; half();
      raise_cs();
      check("R1 sck ignored, dac", 32'(dac_word), 32'h9999);
      check("R1 sck ignored, range", 32'(range_code), 32'h5);
      frame(4'h1, 16'h0000);
      check("R1 staged word intact", 32'(dac_word), 32'h1357);

      // R3 overlong frame, R4 no change before strobe
      shift_bits(32'h00F2C0DE, 24);
      check("R4 dac steady while shifting", 32'(dac_word), 32'h1357);
      raise_cs();
      check("R3 last 20 bits used", 32'(dac_word), 32'hC0DE);
      check("R3 range kept", 32'(range_code), 32'h5);

      // R13 sck rise on the same clock as the strobe
      shift_bits(32'h0002F00D, 20);
      @(negedge clk);
      sdi = 1'b1; sck = 1'b1; cs_n = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
      repeat (8) @(negedge clk);
      check("R13 dac from pre-edge frame", 32'(dac_word), 32'hF00D);
      check("R13 range unchanged", 32'(range_code), 32'h5);

      // R11 readback, shifted out per R2
      frame(4'hE, 16'h0000);
      check("R11 dac unchanged", 32'(dac_word), 32'hF00D);
      check("R2 first status bit on sdo", 32'(sdo), 32'h0);
      cs_n = 1'b0;
      half();
      for (int i = 19; i >= 0; i--) begin
         sdi = 1'b0;
         half();
         cap[i] = sdo;
         sck = 1'b1;
         half();
         sck = 1'b0;
      end
      half();
      check("R11 status word shifted out (R2)", 32'(cap), 32'h5F00D);
      raise_cs();

      // R12 asynchronous clear mid-run
      frame(4'h0, 16'hABCD);
      shift_bits(32'h000FFFFF, 20);
      check("R2 sdo before clear", 32'(sdo), 32'h1);
      #3 clr_n = 1'b0;
      #2;
      check("R12 dac cleared async", 32'(dac_word), 32'h0);
      check("R12 range cleared async", 32'(range_code), 32'h0);
      check("R12 shift reg cleared (sdo)", 32'(sdo), 32'h0);
      cs_n = 1'b1; sdi = 1'b0;
      repeat (4) @(negedge clk);
      clr_n = 1'b1;
      repeat (4) @(negedge clk);
      frame(4'h1, 16'h0000);
      check("R12 input buffer cleared", 32'(dac_word), 32'h0);

      finish_run();
   end

endmodule